// File: doc/BRIEF.md
# Predicated Vector Splice Unit

This block joins two source vectors of 64-bit lanes into one result vector, with a per-lane predicate mask in control. It finds the lowest and the highest set predicate bits and keeps every lane of source A between those two positions, both included. Lanes inside that span are kept even when their own predicate bit is clear. The kept run is packed into the lowest lanes of the result in its original order. Every result lane above it is filled from source B, starting at B's lane 0 and going up.

The lane count is a parameter. It covers vectors from 128 to 2048 bits, which is 2 to 32 lanes. A request is a single cycle with `in_valid` high. The result is registered and appears one clock later with `out_valid`. The output stage is a two-state machine. `ST_EMPTY` means no result is held. `ST_LOADED` means a fresh result is on the output. The transitions are:
- `ST_EMPTY` to `ST_LOADED` on `in_valid` (load).
- `ST_LOADED` to `ST_LOADED` on `in_valid` (reload).
- `ST_LOADED` to `ST_EMPTY` when `in_valid` is low (drain).
- `ST_EMPTY` to `ST_EMPTY` when `in_valid` is low (idle).

Synchronous reset forces `ST_EMPTY`.

Top module: `pred_splice_unit`

## Requirements
- R1: Each lane is 64 bits. Lane k of each bus occupies bits [64k+63:64k]. The result has `LANES` lanes, the same count as each source, with `LANES` from 2 to 32.
- R2: The segment taken from source A starts at the lowest-numbered set predicate bit and ends at the highest-numbered set predicate bit, both included.
- R3: Lanes inside the span are copied whatever their own predicate bit is. With every predicate bit set, the result equals source A.
- R4: The segment is placed from result lane 0 upward, keeping its lane order. Result lane 0 is source A's lane at the lowest set predicate bit.
- R5: For a segment of n lanes, result lane j with j ≥ n takes source B lane j−n.
- R6: With no predicate bit set, the result equals source B unchanged.
- R7: Predicate bit i governs source A lane i. With only the top bit set, result lane 0 is A's top lane and lanes 1 and up are B lanes 0 to LANES−2.
- R8: `out_valid` is high in the cycle after an accepted `in_valid` and low after a cycle with `in_valid` low. `result` then carries that request's value.
- R9: A synchronous active-high `rst` drives `out_valid` low on the next edge, even if `in_valid` is high.
- R10: While `in_valid` stays low, `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for one cycle |
| src_a | input | 64*LANES | First source, segment supplier |
| src_b | input | 64*LANES | Second source, fill supplier |
| pred | input | LANES | Per-lane predicate, bit i for lane i |
| out_valid | output | 1 | Result is fresh this cycle |
| result | output | 64*LANES | Registered spliced vector |

## Verification
The assertions assume that `src_a`, `src_b` and `pred` are known and steady around each rising edge where `in_valid` is high. They also assume that `rst` is held for at least one edge before the first request. The bench drives every input at the falling edge, from the initial block only, and holds reset for several cycles first. This keeps the sampled values free of races and unknowns.

The stimulus mixes two kinds of predicate. Fully random predicates produce sparse masks with holes in the span. Directed masks cover a single lane, the top lane alone, all lanes, and no lanes. Each case is driven with fresh random lane data, so that a misplaced lane shows up as a data mismatch.

// File: rtl/vsplice_pkg.sv
package vsplice_pkg;

    localparam int LANE_W = 64;

    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } ostate_t;

endpackage

// File: rtl/vsplice_span_finder.sv
module vsplice_span_finder #(
    parameter int LANES = 4,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] pred,
    output logic             any_set,
    output logic [IDX_W-1:0] first_idx,
    output logic [IDX_W-1:0] last_idx,
    output logic [CNT_W-1:0] seg_len
);

    // Upward priority encoder: lowest set bit wins (scan top-down, last write kept).
    always_comb begin
        first_idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pred[i]) first_idx = IDX_W'(i);
        end
    end

    // Downward priority encoder: highest set bit wins.
    always_comb begin
        last_idx = '0;
        for (int i = 0; i < LANES; i++) begin
            if (pred[i]) last_idx = IDX_W'(i);
        end
    end

    // Segment length, inactive lanes inside the span included.
    always_comb begin
        any_set = |pred;
        if (any_set) begin
            seg_len = CNT_W'(last_idx) - CNT_W'(first_idx) + CNT_W'(1);
        end else begin
            seg_len = '0;
        end
    end

endmodule

// File: rtl/vsplice_lane_mux.sv
module vsplice_lane_mux
    import vsplice_pkg::*;
#(
    parameter int LANES = 4,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CNT_W = $clog2(LANES + 1),
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic [BUS_W-1:0] src_a,
    input  logic [BUS_W-1:0] src_b,
    input  logic [IDX_W-1:0] first_idx,
    input  logic [CNT_W-1:0] seg_len,
    output logic [BUS_W-1:0] mixed
);

    lane_t a_arr [LANES];
    lane_t b_arr [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_unpack
        assign a_arr[k] = src_a[k*LANE_W +: LANE_W];
        assign b_arr[k] = src_b[k*LANE_W +: LANE_W];
    end

    // One selector per result lane: segment lane first+j, else fill lane j-len.
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [IDX_W-1:0] a_pos;
        logic [IDX_W-1:0] b_pos;
        logic             from_a;
        lane_t            pick;

        always_comb begin
            from_a = CNT_W'(j) < seg_len;
            a_pos  = first_idx + IDX_W'(j);
            b_pos  = IDX_W'(CNT_W'(j) - seg_len);
            if (from_a) begin
                pick = a_arr[a_pos];
            end else begin
                pick = b_arr[b_pos];
            end
        end

        assign mixed[j*LANE_W +: LANE_W] = pick;
    end

endmodule

// File: rtl/vsplice_out_stage.sv
module vsplice_out_stage
    import vsplice_pkg::*;
#(
    parameter int LANES = 4,
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] mixed,
    output logic             out_valid,
    output logic [BUS_W-1:0] result
);

    ostate_t state_q;
    ostate_t state_d;
    logic [BUS_W-1:0] data_q;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output data register, loaded only on an accepted request.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            data_q <= mixed;
        end
    end

    assign out_valid = (state_q == ST_LOADED);
    assign result    = data_q;

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: rtl/pred_splice_unit.sv
module pred_splice_unit
    import vsplice_pkg::*;
#(
    parameter int LANES = 4,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CNT_W = $clog2(LANES + 1),
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] src_a,
    input  logic [BUS_W-1:0] src_b,
    input  logic [LANES-1:0] pred,
    output logic             out_valid,
    output logic [BUS_W-1:0] result
);

    logic             any_set;
    logic [IDX_W-1:0] first_idx;
    logic [IDX_W-1:0] last_idx;
    logic [CNT_W-1:0] seg_len;
    logic [BUS_W-1:0] mixed;
    lane_t            head_lane;

    vsplice_span_finder #(.LANES(LANES)) i_span (
        .pred      (pred),
        .any_set   (any_set),
        .first_idx (first_idx),
        .last_idx  (last_idx),
        .seg_len   (seg_len)
    );

    vsplice_lane_mux #(.LANES(LANES)) i_mux (
        .src_a     (src_a),
        .src_b     (src_b),
        .first_idx (first_idx),
        .seg_len   (seg_len),
        .mixed     (mixed)
    );

    vsplice_out_stage #(.LANES(LANES)) i_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .mixed     (mixed),
        .out_valid (out_valid),
        .result    (result)
    );

    // Source A lane at the lowest active predicate bit, for the head check.
    assign head_lane = src_a[first_idx*LANE_W +: LANE_W];

    // R2
    span_bounds_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && any_set) |-> (pred[first_idx] && pred[last_idx] && first_idx <= last_idx));

    // R6
    passthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pred == '0) |=> (result == $past(src_b)));

    // R3
    full_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && &pred) |=> (result == $past(src_a)));

    // R4
    head_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && |pred) |=> (result[LANE_W-1:0] == $past(head_lane)));

endmodule

// File: tb/test_pred_splice_unit.sv
module test_pred_splice_unit;

    localparam int L  = 8;
    localparam int W  = 64;
    localparam int BW = L * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [BW-1:0] src_a = '0;
    logic [BW-1:0] src_b = '0;
    logic [L-1:0]  pred = '0;
    logic          out_valid;
    logic [BW-1:0] result;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [BW-1:0] exp;
        string         tag;
    } item_t;

    item_t         sb[$];
    logic [BW-1:0] last_exp;

    always #10 clk = ~clk;

    pred_splice_unit #(.LANES(L)) i_pred_splice_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .src_a     (src_a),
        .src_b     (src_b),
        .pred      (pred),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [BW-1:0] model(logic [BW-1:0] a, logic [BW-1:0] b, logic [L-1:0] p);
        logic [BW-1:0] r;
        int f = -1;
        int t = -1;
        int n;
        for (int i = 0; i < L; i++) begin
            if (p[i]) begin
                if (f < 0) f = i;
                t = i;
            end
        end
        n = (f < 0) ? 0 : t - f + 1;
        for (int j = 0; j < L; j++) begin
            if (j < n) r[j*W +: W] = a[(f+j)*W +: W];
            else       r[j*W +: W] = b[(j-n)*W +: W];
        end
        return r;
    endfunction

    function automatic logic [BW-1:0] rand_vec();
        logic [BW-1:0] v;
        for (int k = 0; k < L; k++) v[k*W +: W] = {$urandom, $urandom};
        return v;
    endfunction

    task automatic check(string tag, logic ok, logic [BW-1:0] act, logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one request per call, expected item pushed to the scoreboard.
    task automatic drive(logic [L-1:0] p, string tag);
        item_t it;
        @(negedge clk);
        src_a    = rand_vec();
        src_b    = rand_vec();
        pred     = p;
        in_valid = 1'b1;
        it.exp   = model(src_a, src_b, p);
        it.tag   = tag;
        last_exp = it.exp;
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops and compares as results appear.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check("R8 unexpected out_valid", 1'b0, result, '0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, result === it.exp, result, it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R9 reset out_valid low", out_valid === 1'b0, BW'(out_valid), '0);
        rst = 1'b0;

        drive('0, "R6 empty predicate passthrough");
        drive('1, "R3 all lanes active");
        drive(8'b0000_0100, "R2 single active lane");
        drive(8'b1000_0000, "R7 only top lane active");
        drive(8'b0000_0001, "R4 only lane 0 active");
        drive(8'b0100_1010, "R3 holes inside span");
        drive(8'b0011_1100, "R5 middle span fill");
        idle(1);
        check("R8 out_valid high after last request", out_valid === 1'b1, BW'(out_valid), BW'(1));
        idle(1);
        check("R8 out_valid low after idle", out_valid === 1'b0, BW'(out_valid), '0);
        check("R10 result held while idle", result === last_exp, result, last_exp);
        idle(2);
        check("R10 result still held", result === last_exp, result, last_exp);

        for (int n = 0; n < 60; n++) begin
            drive(L'($urandom), "R5 random predicate");
            if (n % 7 == 3) idle(1);
        end
        idle(2);

        // R9: reset beats a simultaneous request.
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b1;
        pred     = '1;
        @(negedge clk);
        check("R9 reset overrides in_valid", out_valid === 1'b0, BW'(out_valid), '0);
        in_valid = 1'b0;
        rst      = 1'b0;
        drive(8'b0110_0000, "R1 lane placement after reset");
        idle(3);

        check("R8 scoreboard drained", sb.size() == 0, BW'(sb.size()), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule